// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block runs clause-22 management transactions to an external PHY from a single 32-bit command word. A write of a well-formed command word starts a complete serial frame on the management clock and data pins. The frame is a run of preamble ones, the start code, the opcode, the PHY and register addresses, the turnaround and sixteen data bits. On a read, the block releases the data pin after the address fields and shifts in the PHY's sixteen-bit reply. The reply then replaces the low half of the stored command word, so software reads it back from the same place.

Software polls an idle flag before issuing the next command. A command written while a frame is in flight is dropped and does not wait, so the port has no back-pressure. The management clock is derived from the system clock by a divider chosen per transaction from four ratios. A port enable gates all pin activity.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: A command write is accepted only when `idle` is 1 and the word has bit 30 and bit 17 both set and exactly one of bit 29 (read) and bit 28 (write) set. Any other write leaves `idle` at 1 and `cmd_rdata` unchanged.
- R2: `idle` equals `mdio_en` AND not busy. It is 0 from the cycle after an accepted write until exactly 64 MDC periods after acceptance.
- R3: The frame is sent MSB first, one bit per MDC period. It consists of 32 ones, then `01`, then word bits 29:28, then word bits 27:23 (PHY), then word bits 22:18 (register), then `10` as turnaround, then word bits 15:0. The data pin changes only at the start of a bit period, while MDC is low.
- R4: Each MDC period is low for its first half and high for its second half. `div_sel` codes 0, 1, 2 and 3 give periods of 8, 16, 32 and 48 system clocks. The code is captured when the command is accepted, and later changes to `div_sel` have no effect on the running frame.
- R5: On a read, `mdio_oe` is 1 for the first 46 bit periods and 0 for the last 18. `mdio_i` is sampled at the MDC rising edge of each of the last 16 periods, MSB first. When the frame ends, bits 15:0 of `cmd_rdata` take the sampled value and bits 31:16 keep the command.
- R6: A command write while a frame is in progress is ignored. The running frame and `cmd_rdata` are unaffected.
- R7: With `mdio_en` at 0, no command is accepted. A running frame is abandoned, and `mdc` and `mdio_oe` are 0 from the next cycle on.
- R8: After reset, `cmd_rdata` is 0, `mdc` and `mdio_oe` are 0, and `idle` follows `mdio_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mdio_en | input | 1 | Management port enable |
| div_sel | input | 2 | MDC divide ratio code |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word to write |
| cmd_rdata | output | 32 | Stored command word, low half replaced by read data |
| idle | output | 1 | Port enabled and ready for a new command |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Drive enable for the management data pin |
| mdio_i | input | 1 | Management data returned from the PHY |

## Verification
The hardest situations to reach are those that depend on the timing inside a frame. These include a write that lands mid-frame, an enable dropped partway through a bit period, and a divide code changed after acceptance. The stimulus waits a fixed number of cycles after a start before each such event, so the event lands well inside a frame. A behavioural PHY in the bench, driven from the reference model's own bit-period count, supplies read data only during the final sixteen periods. A sample taken one bit period early or late therefore shows up as a wrong word.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_BITS   = 64;
  localparam int PRE_BITS     = 32;
  localparam int RD_DRIVE     = 46;
  localparam int RD_DATA_AT   = 48;
  localparam int DATA_BITS    = 16;
  localparam int SLOT_W       = $clog2(FRAME_BITS);

  localparam int CB_START     = 30;
  localparam int CB_READ      = 29;
  localparam int CB_WRITE     = 28;
  localparam int CB_TURN      = 17;

  typedef logic [FRAME_BITS-1:0] frame_t;

  function automatic logic cmd_ok(input logic [31:0] w);
    return w[CB_START] & w[CB_TURN] & (w[CB_READ] ^ w[CB_WRITE]);
  endfunction

  function automatic frame_t build_frame(input logic [31:0] w);
    return {{PRE_BITS{1'b1}}, 2'b01, w[29:28], w[27:23], w[22:18], 2'b10, w[15:0]};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [RW-1:0] ratio,
  output logic          mdc,
  output logic          rise,
  output logic          slot_end
);
  logic [RW-1:0] cnt;
  logic [RW-1:0] half;

  assign half     = ratio >> 1;
  assign rise     = run && (cnt == half - 1'b1);
  assign slot_end = run && (cnt == ratio - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || slot_end) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (rise) mdc <= 1'b1;
    end
  end

  p_rise_high_r4: assert property (@(posedge clk) disable iff (!rst_n) rise |=> mdc);
  p_end_low_r4:   assert property (@(posedge clk) disable iff (!rst_n) slot_end |=> !mdc);
  p_stop_low_r7:  assert property (@(posedge clk) disable iff (!rst_n) !run |=> !mdc);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 abort,
  input  frame_t               frame,
  input  logic                 is_read,
  input  logic                 rise,
  input  logic                 slot_end,
  input  logic                 mdio_i,
  output logic                 busy,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 done,
  output logic [DATA_BITS-1:0] rd_data
);
  logic [SLOT_W-1:0] slot;
  frame_t            shreg;
  logic              rd_q;
  logic              last;

  assign last = (int'(slot) == FRAME_BITS - 1);
  assign done = busy && slot_end && last && !abort;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      slot    <= '0;
      shreg   <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      rd_q    <= 1'b0;
    end else if (abort) begin
      busy    <= 1'b0;
      mdio_oe <= 1'b0;
    end else if (start) begin
      busy    <= 1'b1;
      slot    <= '0;
      shreg   <= {frame[FRAME_BITS-2:0], 1'b0};
      mdio_o  <= frame[FRAME_BITS-1];
      mdio_oe <= 1'b1;
      rd_q    <= is_read;
    end else if (busy && slot_end) begin
      if (last) begin
        busy    <= 1'b0;
        mdio_oe <= 1'b0;
        mdio_o  <= 1'b0;
      end else begin
        slot    <= slot + 1'b1;
        mdio_o  <= shreg[FRAME_BITS-1];
        shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
        mdio_oe <= !(rd_q && (int'(slot) + 1 >= RD_DRIVE));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (busy && rise && rd_q && !abort && int'(slot) >= RD_DATA_AT)
      rd_data <= {rd_data[DATA_BITS-2:0], mdio_i};
  end

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rd_q && int'(slot) >= RD_DRIVE |-> !mdio_oe);
  p_full_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !$past(abort) |-> int'($past(slot)) == FRAME_BITS - 1);
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_C0 = 8,
  parameter int DIV_C1 = 16,
  parameter int DIV_C2 = 32,
  parameter int DIV_C3 = 48,
  parameter int RW     = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mdio_en,
  input  logic [1:0]  div_sel,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_rdata,
  output logic        idle,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic                 busy, done, accept, rise, slot_end;
  logic [RW-1:0]        ratio_q, ratio_sel;
  logic [DATA_BITS-1:0] rd_data;
  logic [31:0]          word_q;

  assign idle      = mdio_en && !busy;
  assign accept    = cmd_wr && idle && cmd_ok(cmd_wdata);
  assign cmd_rdata = word_q;

  always_comb begin
    case (div_sel)
      2'd0:    ratio_sel = RW'(DIV_C0);
      2'd1:    ratio_sel = RW'(DIV_C1);
      2'd2:    ratio_sel = RW'(DIV_C2);
      default: ratio_sel = RW'(DIV_C3);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q  <= '0;
      ratio_q <= RW'(DIV_C0);
    end else if (accept) begin
      word_q  <= cmd_wdata;
      ratio_q <= ratio_sel;
    end else if (done && word_q[CB_READ]) begin
      word_q[DATA_BITS-1:0] <= rd_data;
    end
  end

  mdio_mdc_gen #(.RW(RW)) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy && mdio_en),
    .ratio    (ratio_q),
    .mdc      (mdc),
    .rise     (rise),
    .slot_end (slot_end)
  );

  mdio_frame_engine u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .abort    (!mdio_en),
    .frame    (build_frame(cmd_wdata)),
    .is_read  (cmd_wdata[CB_READ]),
    .rise     (rise),
    .slot_end (slot_end),
    .mdio_i   (mdio_i),
    .busy     (busy),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .done     (done),
    .rd_data  (rd_data)
  );

  p_idle_drop_r2: assert property (@(posedge clk) disable iff (!rst_n) accept |=> !idle);
  p_busy_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && busy && !done |=> cmd_rdata == $past(cmd_rdata));
  p_bad_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && idle && !(cmd_wdata[CB_START] && cmd_wdata[CB_TURN]) |=> idle);
  p_disable_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mdio_en |=> !mdc && !mdio_oe);
endmodule

// File: tb/mdio_mgmt_ctrl_test.sv
module mdio_mgmt_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mdio_en = 1'b1;
  logic [1:0]  div_sel = 2'd0;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic        idle, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // reference model state
  bit          m_busy = 0;
  bit          m_rd = 0;
  int          m_j = 0;
  int          m_n = 8;
  logic [31:0] m_word = '0;
  logic [63:0] m_frame = '0;
  logic [15:0] m_cap = '0;
  logic [15:0] phy_data = 16'h0000;

  always #5 clk = ~clk;

  mdio_mgmt_ctrl uut (
    .clk(clk), .rst_n(rst_n), .mdio_en(mdio_en), .div_sel(div_sel),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
    .idle(idle), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  function automatic int ratio_of(input logic [1:0] d);
    case (d)
      2'd0: return 8;
      2'd1: return 16;
      2'd2: return 32;
      default: return 48;
    endcase
  endfunction

  function automatic bit well_formed(input logic [31:0] w);
    return w[30] && w[17] && (w[29] != w[28]);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on every edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_word = '0; m_j = 0;
    end else if (!mdio_en) begin
      m_busy = 0;
    end else if (m_busy) begin
      m_j++;
      if (m_rd && (m_j % m_n) == m_n / 2 && (m_j / m_n) >= 48)
        m_cap = {m_cap[14:0], mdio_i};
      if (m_j == 64 * m_n) begin
        m_busy = 0;
        if (m_rd) m_word[15:0] = m_cap;
      end
    end else if (cmd_wr && well_formed(cmd_wdata)) begin
      m_busy  = 1;
      m_j     = 0;
      m_word  = cmd_wdata;
      m_n     = ratio_of(div_sel);
      m_rd    = cmd_wdata[29];
      m_frame = {32'hFFFF_FFFF, 2'b01, cmd_wdata[29:18], 2'b10, cmd_wdata[15:0]};
    end
  end

  // per-cycle comparison and PHY reply
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int  slot;
      bit  e_mdc, e_oe;
      slot  = m_j / m_n;
      e_mdc = m_busy && ((m_j % m_n) >= m_n / 2);
      e_oe  = m_busy && (!m_rd || slot < 46);
      chk(idle == (!m_busy && mdio_en), "R2 idle", 32'(idle), 32'(!m_busy && mdio_en));
      chk(mdc == e_mdc, "R4 mdc", 32'(mdc), 32'(e_mdc));
      chk(mdio_oe == e_oe, "R5 oe", 32'(mdio_oe), 32'(e_oe));
      if (e_oe) chk(mdio_o == m_frame[63 - slot], "R3 data bit", 32'(mdio_o), 32'(m_frame[63 - slot]));
      chk(cmd_rdata == m_word, "R1 word", cmd_rdata, m_word);
      mdio_i <= (m_busy && m_rd && slot >= 48) ? phy_data[63 - slot] : 1'b1;
    end
  end

  task automatic issue(input logic [31:0] w, input logic [1:0] d);
    @(posedge clk); #2;
    cmd_wr = 1'b1; cmd_wdata = w; div_sel = d;
    @(posedge clk); #2;
    cmd_wr = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!idle);
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  initial begin
    logic [31:0] w;
    wait_cycles(3); #2;
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state
    chk(cmd_rdata == 32'h0, "R8 reset word", cmd_rdata, 32'h0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R8 reset pins", {mdc, mdio_oe}, 0);
    chk(idle == 1'b1, "R8 reset idle", 32'(idle), 1);

    // R3/R6: write frame with a second write landing mid-frame
    w = 32'h5000_0000 | 32'h4002_0000 | (5'd17 << 23) | (5'd9 << 18) | 32'hBEEF;
    issue(w, 2'd0);
    @(negedge clk);
    chk(idle == 1'b0, "R2 idle drop", 32'(idle), 0);
    wait_cycles(100);
    issue(32'h6002_1234, 2'd3);
    @(negedge clk);
    chk(cmd_rdata == w, "R6 busy write ignored", cmd_rdata, w);
    wait_idle();
    chk(cmd_rdata == w, "R6 word after frame", cmd_rdata, w);

    // R5: read frame at divide code 1
    phy_data = 16'hA5C3;
    w = 32'h6002_0000 | (5'd3 << 23) | (5'd1 << 18) | 32'h0000_1111;
    issue(w, 2'd1);
    wait_idle();
    chk(cmd_rdata == {w[31:16], 16'hA5C3}, "R5 read reply", cmd_rdata, {w[31:16], 16'hA5C3});

    // R1: malformed commands are dropped
    for (int k = 0; k < 4; k++) begin
      logic [31:0] bad;
      case (k)
        0: bad = 32'h2002_0000;
        1: bad = 32'h6000_0000;
        2: bad = 32'h7002_0000;
        default: bad = 32'h4002_0000;
      endcase
      issue(bad, 2'd0);
      @(negedge clk);
      chk(idle == 1'b1, "R1 bad cmd idle", 32'(idle), 1);
      chk(cmd_rdata == {w[31:16], 16'hA5C3}, "R1 bad cmd word", cmd_rdata, {w[31:16], 16'hA5C3});
    end

    // R7: disabled port accepts nothing
    @(posedge clk); #2; mdio_en = 1'b0;
    issue(32'h5002_0042, 2'd0);
    @(negedge clk);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R7 disabled pins", {mdc, mdio_oe}, 0);
    @(posedge clk); #2; mdio_en = 1'b1;
    @(negedge clk);
    chk(idle == 1'b1, "R7 no start while off", 32'(idle), 1);

    // R7: abort mid-frame
    issue(32'h5002_0077, 2'd0);
    wait_cycles(37); #2;
    mdio_en = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R7 abort pins", {mdc, mdio_oe}, 0);
    @(posedge clk); #2; mdio_en = 1'b1;
    @(negedge clk);
    chk(idle == 1'b1, "R7 idle after abort", 32'(idle), 1);

    // R4: divide codes 2 and 3, code changed while running
    issue(32'h5082_8001, 2'd2);
    wait_cycles(200); #2; div_sel = 2'd0;
    wait_idle();
    issue(32'h57FE_FFFF, 2'd3);
    wait_cycles(300); #2; div_sel = 2'd1;
    wait_idle();

    // R5: read at divide code 3 with edge data pattern
    phy_data = 16'h8001;
    w = 32'h67FE_0000;
    issue(w, 2'd3);
    wait_idle();
    chk(cmd_rdata == {w[31:16], 16'h8001}, "R5 read reply 2", cmd_rdata, {w[31:16], 16'h8001});

    wait_cycles(4);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule